// File: doc/BRIEF.md
# Extendable Stack Pointer Unit

This unit holds the stack pointer of an 8-bit microcontroller core. In classic mode it behaves as an 8-bit pointer into the 256-byte internal data RAM and wraps within it. In extended mode it behaves as an 11-bit pointer. That pointer runs past the top of internal RAM into the upper 1792 bytes of a 2 KB on-chip XRAM, so stacks up to 2 KB deep become possible. The lowest 256 XRAM bytes never hold stack data.

The core issues one-cycle push and pop commands. The unit presents the current stack location and a flag that steers the access to internal RAM or to XRAM.

- A push moves the pointer up first, so the byte lands at the new location in the cycle after the command.
- A pop reads at the current location, then moves the pointer down.

Software sees the pointer through two special-function registers, which share the core's SFR write strobe and read data:

- The low byte sits at SFR address 81h.
- The upper three bits sit in bits [2:0] of SFR address B7h.

Top module: `xstack_pointer`

## Requirements
- R1: After reset the pointer is 007h: stk_addr reads 007h, SFR 81h reads 07h and SFR B7h reads 00h, so the first push targets 008h.
- R2: A push (push=1, pop=0, no SFR write) raises the pointer by one; stk_addr shows the raised value from the cycle after the push.
- R3: A pop (pop=1, push=0, no SFR write) leaves stk_addr at the read location during the pop cycle; from the next cycle it is one lower.
- R4: With ext_mode=0 only the low 8 bits step (FFh to 00h on push, 00h to FFh on pop). stk_addr is {000b, low byte} and stk_in_xram is 0. The upper 3 bits stay stored unchanged.
- R5: With ext_mode=1 all 11 bits step: 0FFh goes to 100h on push and 100h goes to 0FFh on pop. 7FFh goes to 000h on push and 000h goes to 7FFh on pop.
- R6: With ext_mode=1, stk_addr equals the 11-bit pointer and stk_in_xram is 1 exactly when it lies in 100h–7FFh.
- R7: An SFR write to 81h loads the low 8 bits from sfr_wdata. A write to B7h loads the upper 3 bits from sfr_wdata[2:0] and ignores sfr_wdata[7:3]. Writes to any other address leave the pointer alone.
- R8: sfr_rdata is combinational on sfr_addr:
  - 81h returns the low byte.
  - B7h returns {00000b, upper 3 bits}.
  - Any other address returns 00h.
- R9: An SFR write to 81h or B7h wins over a push or pop in the same cycle, and the command is dropped. Push and pop together change nothing. A push alongside a write to an unrelated SFR address still steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ext_mode | input | 1 | 1 selects the 11-bit extended pointer |
| push | input | 1 | Push command, one cycle per byte |
| pop | input | 1 | Pop command, one cycle per byte |
| sfr_wr | input | 1 | SFR write strobe |
| sfr_addr | input | 8 | SFR address for write and read |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | SFR read data for sfr_addr |
| stk_addr | output | 11 | Current stack location |
| stk_in_xram | output | 1 | 1 when the stack location lies in XRAM |

## Verification
The bench drives the pointer across every boundary:
- Classic FFh/00h in both directions. A design that let the carry into the upper bits would send a classic stack into XRAM.
- Extended 0FFh/100h and 7FFh/000h. A design that wrapped at 8 bits in extended mode would overwrite the bottom of internal RAM instead of reaching XRAM.
- A pop at the wrong moment would skew every return address by one.

It writes B7h with junk in the high bits and collides SFR writes with push, pop and both at once. A wrong write priority or a missed field mask shows up as a pointer that is off by one or has stray upper bits.

// File: rtl/sp_pkg.sv
package sp_pkg;
  localparam int PTR_W = 11;
  localparam int LO_W  = 8;
  localparam int HI_W  = PTR_W - LO_W;
  localparam int ADR_W = 8;

  localparam logic [ADR_W-1:0] SFR_SP_LO = 8'h81;
  localparam logic [ADR_W-1:0] SFR_SP_HI = 8'hB7;
  localparam logic [LO_W-1:0]  SP_RST    = 8'h07;

  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_INC  = 2'd1,
    OP_DEC  = 2'd2
  } sp_op_e;
endpackage

// File: rtl/xsp_step.sv
// Next pointer value for a push or pop in either mode.
module xsp_step #(
  parameter int PTR_W = 11,
  parameter int LO_W  = 8
) (
  input  logic [PTR_W-1:0] cur,
  input  sp_pkg::sp_op_e   op,
  input  logic             ext,
  output logic [PTR_W-1:0] nxt
);
  localparam logic [PTR_W-1:0] ONE_F = {{(PTR_W-1){1'b0}}, 1'b1};
  localparam logic [LO_W-1:0]  ONE_L = {{(LO_W-1){1'b0}}, 1'b1};

  logic [PTR_W-1:0] full_inc, full_dec;
  logic [LO_W-1:0]  lo_inc, lo_dec;

  assign full_inc = cur + ONE_F;
  assign full_dec = cur - ONE_F;
  assign lo_inc   = cur[LO_W-1:0] + ONE_L;
  assign lo_dec   = cur[LO_W-1:0] - ONE_L;

  always_comb begin
    case (op)
      sp_pkg::OP_INC: nxt = ext ? full_inc : {cur[PTR_W-1:LO_W], lo_inc};
      sp_pkg::OP_DEC: nxt = ext ? full_dec : {cur[PTR_W-1:LO_W], lo_dec};
      default:        nxt = cur;
    endcase
  end
endmodule

// File: rtl/xsp_sfr_port.sv
// SFR decode for the two pointer registers and their readback.
module xsp_sfr_port #(
  parameter int PTR_W = 11,
  parameter int LO_W  = 8,
  parameter int ADR_W = 8
) (
  input  logic             wr,
  input  logic [ADR_W-1:0] addr,
  input  logic [PTR_W-1:0] cur,
  output logic             wr_lo,
  output logic             wr_hi,
  output logic [LO_W-1:0]  rdata
);
  localparam int HI_W = PTR_W - LO_W;

  logic hit_lo, hit_hi;

  assign hit_lo = (addr == sp_pkg::SFR_SP_LO);
  assign hit_hi = (addr == sp_pkg::SFR_SP_HI);
  assign wr_lo  = wr && hit_lo;
  assign wr_hi  = wr && hit_hi;

  always_comb begin
    if (hit_lo)
      rdata = cur[LO_W-1:0];
    else if (hit_hi)
      rdata = {{(LO_W-HI_W){1'b0}}, cur[PTR_W-1:LO_W]};
    else
      rdata = '0;
  end
endmodule

// File: rtl/xsp_map.sv
// Maps the stored pointer to a stack location and a memory select.
module xsp_map #(
  parameter int PTR_W = 11,
  parameter int LO_W  = 8
) (
  input  logic [PTR_W-1:0] cur,
  input  logic             ext,
  output logic [PTR_W-1:0] addr,
  output logic             in_xram
);
  localparam int HI_W = PTR_W - LO_W;

  always_comb begin
    if (ext) begin
      addr    = cur;
      in_xram = |cur[PTR_W-1:LO_W];
    end else begin
      addr    = {{HI_W{1'b0}}, cur[LO_W-1:0]};
      in_xram = 1'b0;
    end
  end
endmodule

// File: rtl/xstack_pointer.sv
module xstack_pointer #(
  parameter int PTR_W = sp_pkg::PTR_W,
  parameter int LO_W  = sp_pkg::LO_W,
  parameter int ADR_W = sp_pkg::ADR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_mode,
  input  logic             push,
  input  logic             pop,
  input  logic             sfr_wr,
  input  logic [ADR_W-1:0] sfr_addr,
  input  logic [LO_W-1:0]  sfr_wdata,
  output logic [LO_W-1:0]  sfr_rdata,
  output logic [PTR_W-1:0] stk_addr,
  output logic             stk_in_xram
);
  localparam int HI_W = PTR_W - LO_W;
  localparam logic [PTR_W-1:0] PTR_RST = {{HI_W{1'b0}}, sp_pkg::SP_RST};

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  logic [PTR_W-1:0] ptr_q, ptr_d, step_nxt;
  logic             ptr_en, wr_lo, wr_hi;
  sp_pkg::sp_op_e   op;

  always_comb begin
    if (push && !pop)      op = sp_pkg::OP_INC;
    else if (pop && !push) op = sp_pkg::OP_DEC;
    else                   op = sp_pkg::OP_HOLD;
  end

  xsp_step #(.PTR_W(PTR_W), .LO_W(LO_W)) u_step (
    .cur (ptr_q),
    .op  (op),
    .ext (ext_mode),
    .nxt (step_nxt)
  );

  xsp_sfr_port #(.PTR_W(PTR_W), .LO_W(LO_W), .ADR_W(ADR_W)) u_sfr (
    .wr    (sfr_wr),
    .addr  (sfr_addr),
    .cur   (ptr_q),
    .wr_lo (wr_lo),
    .wr_hi (wr_hi),
    .rdata (sfr_rdata)
  );

  xsp_map #(.PTR_W(PTR_W), .LO_W(LO_W)) u_map (
    .cur     (ptr_q),
    .ext     (ext_mode),
    .addr    (stk_addr),
    .in_xram (stk_in_xram)
  );

  // next state: SFR write outranks push/pop
  always_comb begin
    ptr_d = ptr_q;
    if (wr_lo)
      ptr_d[LO_W-1:0] = sfr_wdata;
    else if (wr_hi)
      ptr_d[PTR_W-1:LO_W] = sfr_wdata[HI_W-1:0];
    else
      ptr_d = step_nxt;
  end

  assign ptr_en = wr_lo || wr_hi || (op != sp_pkg::OP_HOLD);

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)      ptr_q <= PTR_RST;
    else if (ptr_en) ptr_q <= ptr_d;
  end
endmodule

// File: rtl/xsp_checker.sv
module xsp_checker #(
  parameter int PTR_W = sp_pkg::PTR_W,
  parameter int LO_W  = sp_pkg::LO_W,
  parameter int ADR_W = sp_pkg::ADR_W
) (
  input logic             clk,
  input logic             rst_s,
  input logic             ext_mode,
  input logic             push,
  input logic             pop,
  input logic             sfr_wr,
  input logic [ADR_W-1:0] sfr_addr,
  input logic [LO_W-1:0]  sfr_wdata,
  input logic [LO_W-1:0]  sfr_rdata,
  input logic [PTR_W-1:0] stk_addr,
  input logic             stk_in_xram
);
  localparam int HI_W = PTR_W - LO_W;
  localparam logic [PTR_W-1:0] ONE_F   = {{(PTR_W-1){1'b0}}, 1'b1};
  localparam logic [PTR_W-1:0] RST_A   = {{HI_W{1'b0}}, sp_pkg::SP_RST};
  localparam logic [PTR_W-1:0] TOP_RAM = {{HI_W{1'b0}}, {LO_W{1'b1}}};
  localparam logic [PTR_W-1:0] BOT_X   = TOP_RAM + ONE_F;

  assert_reset_val_R1: assert property (@(posedge clk)
    !rst_s |=> stk_addr == RST_A);

  assert_push_step_R2: assert property (@(posedge clk) disable iff (!rst_s)
    (push && !pop && !sfr_wr && ext_mode && stk_addr != {PTR_W{1'b1}})
    |=> (!ext_mode || stk_addr == $past(stk_addr) + ONE_F));

  assert_pop_step_R3: assert property (@(posedge clk) disable iff (!rst_s)
    (pop && !push && !sfr_wr && ext_mode && stk_addr != '0)
    |=> (!ext_mode || stk_addr == $past(stk_addr) - ONE_F));

  assert_classic_wrap_R4: assert property (@(posedge clk) disable iff (!rst_s)
    (push && !pop && !sfr_wr && !ext_mode && stk_addr[LO_W-1:0] == {LO_W{1'b1}})
    |=> (ext_mode || stk_addr == '0));

  assert_ext_cross_R5: assert property (@(posedge clk) disable iff (!rst_s)
    (push && !pop && !sfr_wr && ext_mode && stk_addr == TOP_RAM)
    |=> (!ext_mode || (stk_addr == BOT_X && stk_in_xram)));

  assert_xram_sel_R6: assert property (@(posedge clk) disable iff (!rst_s)
    stk_in_xram |-> (stk_addr[PTR_W-1:LO_W] != '0));

  assert_wr_lo_R7: assert property (@(posedge clk) disable iff (!rst_s)
    (sfr_wr && sfr_addr == sp_pkg::SFR_SP_LO)
    |=> stk_addr[LO_W-1:0] == $past(sfr_wdata));

  assert_sp_read_R8: assert property (@(posedge clk) disable iff (!rst_s)
    (sfr_addr == sp_pkg::SFR_SP_LO) |-> sfr_rdata == stk_addr[LO_W-1:0]);

  assert_sph_read_R8: assert property (@(posedge clk) disable iff (!rst_s)
    (sfr_addr == sp_pkg::SFR_SP_HI) |-> sfr_rdata[LO_W-1:HI_W] == '0);

  assert_both_hold_R9: assert property (@(posedge clk) disable iff (!rst_s)
    (push && pop && !sfr_wr)
    |=> (ext_mode != $past(ext_mode) || $stable(stk_addr)));
endmodule

bind xstack_pointer xsp_checker #(.PTR_W(PTR_W), .LO_W(LO_W), .ADR_W(ADR_W)) i_chk (
  .clk         (clk),
  .rst_s       (rst_s),
  .ext_mode    (ext_mode),
  .push        (push),
  .pop         (pop),
  .sfr_wr      (sfr_wr),
  .sfr_addr    (sfr_addr),
  .sfr_wdata   (sfr_wdata),
  .sfr_rdata   (sfr_rdata),
  .stk_addr    (stk_addr),
  .stk_in_xram (stk_in_xram)
);

// File: tb/test_xstack_pointer.sv
module test_xstack_pointer;
  logic        clk, rst_n, ext_mode, push, pop, sfr_wr;
  logic [7:0]  sfr_addr, sfr_wdata, sfr_rdata;
  logic [10:0] stk_addr;
  logic        stk_in_xram;

  int total = 0;
  int bad   = 0;

  xstack_pointer i_xstack_pointer (
    .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .push(push), .pop(pop),
    .sfr_wr(sfr_wr), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
    .sfr_rdata(sfr_rdata), .stk_addr(stk_addr), .stk_in_xram(stk_in_xram)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct packed {
    logic [10:0] a;
    logic        x;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  exp_t  got_e;
  string got_t;

  logic [10:0] m_ptr;

  function automatic logic [7:0] m_read(input logic [7:0] a);
    if (a == 8'h81)      return m_ptr[7:0];
    else if (a == 8'hB7) return {5'b0, m_ptr[10:8]};
    else                 return 8'h00;
  endfunction

  // scoreboard monitor: compares after each edge
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      got_e = exp_q.pop_front();
      got_t = tag_q.pop_front();
      total++;
      if (stk_addr !== got_e.a || stk_in_xram !== got_e.x) begin
        bad++;
        $display("FAIL %s: addr=%h xram=%b expected addr=%h xram=%b",
                 got_t, stk_addr, stk_in_xram, got_e.a, got_e.x);
      end
    end
  end

  task automatic cyc(input logic p, input logic po, input logic w,
                     input logic [7:0] a, input logic [7:0] d,
                     input logic e, input string tag);
    exp_t ex;
    @(negedge clk);
    push = p; pop = po; sfr_wr = w; sfr_addr = a; sfr_wdata = d; ext_mode = e;
    if (w && a == 8'h81)       m_ptr[7:0]  = d;
    else if (w && a == 8'hB7)  m_ptr[10:8] = d[2:0];
    else if (p && !po)         m_ptr = e ? m_ptr + 11'd1 : {m_ptr[10:8], m_ptr[7:0] + 8'd1};
    else if (po && !p)         m_ptr = e ? m_ptr - 11'd1 : {m_ptr[10:8], m_ptr[7:0] - 8'd1};
    ex.a = e ? m_ptr : {3'b000, m_ptr[7:0]};
    ex.x = e && (m_ptr[10:8] != 3'b000);
    exp_q.push_back(ex);
    tag_q.push_back(tag);
  endtask

  task automatic rd_chk(input logic [7:0] a, input string tag);
    logic [7:0] exp_v;
    cyc(1'b0, 1'b0, 1'b0, a, 8'h00, ext_mode, tag);
    exp_v = m_read(a);
    #1;
    total++;
    if (sfr_rdata !== exp_v) begin
      bad++;
      $display("FAIL %s: rdata[%h]=%h expected %h", tag, a, sfr_rdata, exp_v);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ext_mode = 1'b0; push = 1'b0; pop = 1'b0; sfr_wr = 1'b0;
    sfr_addr = 8'h00; sfr_wdata = 8'h00;
    m_ptr = 11'h007;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    total++;  // R1 reset pointer
    if (stk_addr !== 11'h007 || stk_in_xram !== 1'b0) begin
      bad++;
      $display("FAIL R1: addr=%h expected 007", stk_addr);
    end
    rd_chk(8'h81, "R1 SP reset");
    rd_chk(8'hB7, "R1 SPH reset");

    // R2 pushes from reset, R3 pop
    cyc(1, 0, 0, 8'h00, 8'h00, 0, "R2 push to 008");
    cyc(1, 0, 0, 8'h00, 8'h00, 0, "R2 push to 009");
    cyc(1, 0, 0, 8'h00, 8'h00, 0, "R2 push to 00A");
    cyc(0, 1, 0, 8'h00, 8'h00, 0, "R3 pop to 009");

    // R4 classic wrap
    cyc(0, 0, 1, 8'h81, 8'hFE, 0, "R7 write SP FE");
    cyc(1, 0, 0, 8'h00, 8'h00, 0, "R4 push to FF");
    cyc(1, 0, 0, 8'h00, 8'h00, 0, "R4 push wraps to 00");
    cyc(0, 1, 0, 8'h00, 8'h00, 0, "R4 pop wraps to FF");

    // R7 SPH write ignores high bits; R4 classic keeps upper bits hidden
    cyc(0, 0, 1, 8'hB7, 8'hFD, 0, "R7 write SPH junk high bits");
    rd_chk(8'hB7, "R7 SPH masked read");
    cyc(0, 0, 0, 8'h00, 8'h00, 1, "R6 ext shows 5FF in xram");
    cyc(0, 0, 0, 8'h00, 8'h00, 0, "R4 classic back to 0FF");

    // R5 extended crossings
    cyc(0, 0, 1, 8'hB7, 8'h00, 1, "R7 SPH=0 ext");
    cyc(1, 0, 0, 8'h00, 8'h00, 1, "R5 push 0FF to 100");
    cyc(0, 1, 0, 8'h00, 8'h00, 1, "R5 pop 100 to 0FF");
    cyc(0, 0, 1, 8'hB7, 8'h07, 1, "R6 SPH=7 ext");
    cyc(1, 0, 0, 8'h00, 8'h00, 1, "R5 push 7FF to 000");
    cyc(0, 1, 0, 8'h00, 8'h00, 1, "R5 pop 000 to 7FF");

    // R9 priority cases
    cyc(1, 0, 1, 8'h81, 8'h40, 1, "R9 write SP beats push");
    cyc(0, 1, 1, 8'hB7, 8'h02, 1, "R9 write SPH beats pop");
    cyc(1, 1, 0, 8'h00, 8'h00, 1, "R9 push and pop hold");
    cyc(1, 0, 1, 8'h90, 8'h55, 1, "R9 unrelated write lets push step");
    rd_chk(8'h90, "R8 other address reads 00");
    rd_chk(8'h81, "R8 SP read");

    // R4 classic pop from 00 keeps upper bits
    cyc(0, 0, 1, 8'h81, 8'h00, 0, "R7 write SP 00 classic");
    cyc(0, 1, 0, 8'h00, 8'h00, 0, "R4 classic pop 00 to FF");
    rd_chk(8'hB7, "R4 upper bits kept");
    cyc(0, 0, 0, 8'h00, 8'h00, 1, "R6 ext reveals 2FF");

    cyc(0, 0, 0, 8'h00, 8'h00, 0, "idle");
    repeat (3) @(posedge clk);
    #3;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule